// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one read or write request into the stream of column addresses for a burst inside a single open row of 256 columns. A caller presents a start column, a length code and an ordering bit together with a one-cycle start strobe. From the next cycle the block puts out one column address per clock with a valid flag, and it marks the final beat with a last flag. A terminate input, which the caller raises for a burst-stop or precharge, ends the burst at once.

The block supports two orderings. In sequential order the address wraps inside an aligned window of the burst length. In interleaved order the address inside that window is the start offset XOR a beat counter. A full-page length walks the whole row, wraps from 255 to 0, and runs until it is terminated. A new start can be issued on the same cycle as a final beat or a terminate, so bursts can follow one another with no gap.

Top module: `col_burst_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `valid_o` and `last_o` are low.
- R2: A start strobe accepted at a clock edge makes `valid_o` high from that edge, with `col_o` equal to the start column. The burst then advances one beat per clock.
- R3: Length code `blen_i` 0, 1, 2 and 3 gives bursts of 1, 2, 4 and 8 beats. `last_o` is high only on the final beat, and `valid_o` falls after that beat unless a new burst is accepted.
- R4: In sequential order (`ilv_i`=0) with length N, the column bits above log2(N) equal those of the start column. The low log2(N) bits equal (start low bits + beat index) mod N.
- R5: In interleaved order (`ilv_i`=1) with length 2, 4 or 8, the low log2(N) bits equal the start column's low bits XOR the 0-based beat index. With length 1 or full page, `ilv_i` has no effect.
- R6: Length codes 4 to 7 select full page. The address is (start + beat index) mod 256, it wraps from 255 to 0, `last_o` is never raised, and the burst runs until terminated.
- R7: `term_i` high at an edge during a burst makes `valid_o` low from that edge on, and the block returns to idle.
- R8: A start strobe during a burst is ignored unless `term_i` is high in the same cycle or the final beat is on the outputs. In those two cases the new burst begins at that edge.
- R9: `term_i` while idle has no effect, and `valid_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| start_i | input | 1 | One-cycle request to begin a burst |
| start_col_i | input | COL_W | Start column of the burst |
| blen_i | input | 3 | Length code: 0..3 give 1,2,4,8 beats; 4..7 give full page |
| ilv_i | input | 1 | 0 selects sequential order, 1 selects interleaved order |
| term_i | input | 1 | Ends the running burst at this edge |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | `col_o` holds a beat |
| last_o | output | 1 | Current beat is the final one of a fixed-length burst |

## Verification
The bench builds the block with the default column width of 8, so the whole 256-column row is one full-page wrap. That makes the 255-to-0 crossing and a run longer than one row reachable in a few hundred cycles. With this width, start columns near the top of the row and in the middle of aligned windows can be used. These starts show that sequential wrap and interleaved XOR stay inside their window and never carry into the upper bits.

// File: rtl/col_burst_pkg.sv
package col_burst_pkg;
  localparam int unsigned BLEN_CODE_W = 3;

  typedef enum logic [BLEN_CODE_W-1:0] {
    BL_ONE   = 3'd0,
    BL_TWO   = 3'd1,
    BL_FOUR  = 3'd2,
    BL_EIGHT = 3'd3,
    BL_PAGE  = 3'd4
  } blen_code_e;

  // Bit 2 of the code selects a whole-row walk; codes 5..7 alias page mode.
  function automatic logic code_is_page(logic [BLEN_CODE_W-1:0] code);
    return code[BLEN_CODE_W-1];
  endfunction
endpackage

// File: rtl/cbg_len_decode.sv
module cbg_len_decode
  import col_burst_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic [BLEN_CODE_W-1:0] code_i,
  input  logic                   ilv_req_i,
  output logic [COL_W-1:0]       mask_o,
  output logic                   page_o,
  output logic                   ilv_o
);
  logic [1:0] log2_len;

  always_comb begin
    page_o   = code_is_page(code_i);
    log2_len = code_i[1:0];
    for (int i = 0; i < int'(COL_W); i++) begin
      mask_o[i] = page_o | (i < int'(log2_len));
    end
    // interleaving is meaningless for a whole-row walk; length 1 has an empty mask
    ilv_o = ilv_req_i & ~page_o;
  end
endmodule

// File: rtl/cbg_seq_state.sv
module cbg_seq_state #(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             page_i,
  input  logic             ilv_i,
  input  logic             term_i,
  output logic             active_o,
  output logic             last_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] mask_o,
  output logic             ilv_o,
  output logic [COL_W-1:0] beat_o
);
  logic             active_q, active_d;
  logic [COL_W-1:0] beat_q, beat_d;
  logic [COL_W-1:0] base_q, mask_q;
  logic             page_q, ilv_q;
  logic             load, last, en_cfg, en_beat;

  assign last   = active_q & ~page_q & (beat_q == mask_q);
  assign load   = start_i & (~active_q | last | term_i);
  assign en_cfg = load;
  assign en_beat = load | active_q;

  always_comb begin
    active_d = active_q;
    beat_d   = beat_q;
    if (load) begin
      active_d = 1'b1;
      beat_d   = '0;
    end else if (active_q) begin
      if (term_i || last) begin
        active_d = 1'b0;
      end else begin
        beat_d = beat_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
    end else begin
      active_q <= active_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
    end else if (en_beat) begin
      beat_q <= beat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
      page_q <= 1'b0;
      ilv_q  <= 1'b0;
    end else if (en_cfg) begin
      base_q <= col_i;
      mask_q <= mask_i;
      page_q <= page_i;
      ilv_q  <= ilv_i;
    end
  end

  assign active_o = active_q;
  assign last_o   = last;
  assign base_o   = base_q;
  assign mask_o   = mask_q;
  assign ilv_o    = ilv_q;
  assign beat_o   = beat_q;

  assert_last_in_burst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> active_o);

  assert_term_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && term_i && !start_i) |=> !active_o);

  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !last_o && !term_i && start_i) |=> $stable(base_o));

  assert_beat_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !last_o && !term_i) |=> (active_o && beat_o == $past(beat_o) + 1'b1));

  assert_page_no_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !last_o && !term_i && !start_i && mask_o == {COL_W{1'b1}} && beat_o == mask_o)
      |=> (active_o && beat_o == '0));
endmodule

// File: rtl/cbg_addr_map.sv
module cbg_addr_map #(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum;

  assign sum = base_i + beat_i;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign col_o[i] = mask_i[i] ? (ilv_i ? (base_i[i] ^ beat_i[i]) : sum[i]) : base_i[i];
  end

  assert_upper_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && $past(valid_i) && beat_i != '0)
      |-> ((col_o & ~mask_i) == ($past(col_o) & ~mask_i)));

  assert_first_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && beat_i == '0) |-> (col_o == base_i));
endmodule

// File: rtl/col_burst_seq.sv
module col_burst_seq
  import col_burst_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [COL_W-1:0]       start_col_i,
  input  logic [BLEN_CODE_W-1:0] blen_i,
  input  logic                   ilv_i,
  input  logic                   term_i,
  output logic [COL_W-1:0]       col_o,
  output logic                   valid_o,
  output logic                   last_o
);
  logic [COL_W-1:0] dec_mask, st_base, st_mask, st_beat;
  logic             dec_page, dec_ilv, st_ilv, st_active, st_last;

  cbg_len_decode #(.COL_W(COL_W)) u_dec (
    .code_i   (blen_i),
    .ilv_req_i(ilv_i),
    .mask_o   (dec_mask),
    .page_o   (dec_page),
    .ilv_o    (dec_ilv)
  );

  cbg_seq_state #(.COL_W(COL_W)) u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .col_i   (start_col_i),
    .mask_i  (dec_mask),
    .page_i  (dec_page),
    .ilv_i   (dec_ilv),
    .term_i  (term_i),
    .active_o(st_active),
    .last_o  (st_last),
    .base_o  (st_base),
    .mask_o  (st_mask),
    .ilv_o   (st_ilv),
    .beat_o  (st_beat)
  );

  cbg_addr_map #(.COL_W(COL_W)) u_map (
    .clk    (clk),
    .rst_n  (rst_n),
    .valid_i(st_active),
    .base_i (st_base),
    .beat_i (st_beat),
    .mask_i (st_mask),
    .ilv_i  (st_ilv),
    .col_o  (col_o)
  );

  assign valid_o = st_active;
  assign last_o  = st_last;

  assert_idle_term_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o && !start_i) |=> !valid_o);
endmodule

// File: tb/test_col_burst_seq.sv
module test_col_burst_seq;
  localparam int COL_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start_i;
  logic [COL_W-1:0] start_col_i;
  logic [2:0]       blen_i;
  logic             ilv_i;
  logic             term_i;
  logic [COL_W-1:0] col_o;
  logic             valid_o;
  logic             last_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [COL_W:0] v;
    string          req;
  } exp_t;
  exp_t q[$];

  col_burst_seq #(.COL_W(COL_W)) i_col_burst_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .blen_i(blen_i), .ilv_i(ilv_i), .term_i(term_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  always #5 clk = ~clk;

  function automatic logic [COL_W:0] expv(int st, int code, bit il, int b);
    int n, m, c;
    bit page;
    page = (code >= 4);
    n = page ? 256 : (1 << code);
    m = n - 1;
    if (page) c = (st + b) % 256;
    else if (il) c = (st & ~m) | ((st ^ b) & m);
    else c = (st & ~m) | ((st + b) & m);
    return {(!page && b == n - 1), 8'(c)};
  endfunction

  // monitor: pop one expected item per valid beat
  always @(negedge clk) begin
    if (rst_n === 1'b1 && valid_o === 1'b1) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R8 unexpected beat: actual col=%0d last=%0d expected no beat", col_o, last_o);
      end else begin
        exp_t e;
        e = q.pop_front();
        if ({last_o, col_o} !== e.v)
          begin
            errors++;
            $display("FAIL %s beat: actual last=%0d col=%0d expected last=%0d col=%0d",
                     e.req, last_o, col_o, e.v[COL_W], e.v[COL_W-1:0]);
          end
      end
    end
  end

  // caller stands on a negedge; returns one negedge later with beat 0 visible
  task automatic launch(int col, int code, bit il, int cnt, bit with_term, string req);
    for (int b = 0; b < cnt; b++) begin
      exp_t e;
      e.v = expv(col, code, il, b);
      e.req = req;
      q.push_back(e);
    end
    start_i = 1'b1; start_col_i = 8'(col); blen_i = 3'(code); ilv_i = il; term_i = with_term;
    @(negedge clk);
    start_i = 1'b0; term_i = 1'b0;
  endtask

  task automatic check_idle(string req);
    checks++;
    if (valid_o !== 1'b0 || q.size() != 0) begin
      errors++;
      $display("FAIL %s idle: actual valid=%0d pending=%0d expected valid=0 pending=0",
               req, valid_o, q.size());
    end
  endtask

  task automatic stop_now(string req);
    term_i = 1'b1;
    @(negedge clk);
    term_i = 1'b0;
    check_idle(req);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; start_col_i = '0; blen_i = '0; ilv_i = 1'b0; term_i = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (valid_o !== 1'b0 || last_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: actual valid=%0d last=%0d expected 0 0", valid_o, last_o);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1");

    // R3 R4: sequential lengths 1,2,4,8
    for (int code = 0; code < 4; code++) begin
      launch(8'h35, code, 1'b0, 1 << code, 1'b0, "R4");
      repeat ((1 << code) - 1) @(negedge clk);
      @(negedge clk);
      check_idle("R3");
    end
    // R5: interleaved lengths 1,2,4,8
    for (int code = 0; code < 4; code++) begin
      launch(8'hA6, code, 1'b1, 1 << code, 1'b0, "R5");
      repeat ((1 << code) - 1) @(negedge clk);
      @(negedge clk);
      check_idle("R5");
    end
    launch(8'hFB, 3, 1'b0, 8, 1'b0, "R4");
    repeat (7) @(negedge clk);
    @(negedge clk);
    check_idle("R4");

    // R6: page burst across the wrap, interleave bit ignored
    launch(250, 4, 1'b1, 10, 1'b0, "R6");
    repeat (9) @(negedge clk);
    stop_now("R7");
    // R6: longer than one row, alias code 7, no last
    launch(3, 7, 1'b0, 300, 1'b0, "R6");
    repeat (299) @(negedge clk);
    stop_now("R6");

    // R7: early stop of an 8-beat burst after 3 beats
    launch(8'h48, 3, 1'b1, 3, 1'b0, "R7");
    repeat (2) @(negedge clk);
    stop_now("R7");

    // R8: busy start ignored
    launch(8'h10, 3, 1'b0, 8, 1'b0, "R8");
    start_i = 1'b1; start_col_i = 8'h99; blen_i = 3'd1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (6) @(negedge clk);
    @(negedge clk);
    check_idle("R8");

    // R8: start with terminate restarts at once
    launch(8'h40, 3, 1'b0, 3, 1'b0, "R8");
    repeat (2) @(negedge clk);
    launch(8'h77, 2, 1'b0, 4, 1'b1, "R8");
    repeat (3) @(negedge clk);
    @(negedge clk);
    check_idle("R8");

    // R8: start on the final beat chains with no gap
    launch(5, 1, 1'b0, 2, 1'b0, "R8");
    @(negedge clk);
    launch(8'h0D, 2, 1'b1, 4, 1'b0, "R8");
    repeat (3) @(negedge clk);
    @(negedge clk);
    check_idle("R8");

    // R9: terminate while idle
    stop_now("R9");
    @(negedge clk);
    check_idle("R9");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule